// File: doc/BRIEF.md
# ADC Acquisition Control and Status

This block is the host-facing control core of an analog-to-digital acquisition front end. It sits on a byte-wide host bus with four addresses. One address is a write-only option register on write and a read-only status register on read. The other addresses load channel entries, read conversion results and give a software start strobe. The block chooses which sources may launch a conversion: the software strobe, an external start pin, or the terminal count of an external timer. It tracks whether the converter is busy.

Two synchronous FIFOs are held inside. The channel FIFO queues the channel entries that the host loads, and each launched conversion takes the next one. The data FIFO collects the converter results for the host to read. A single interrupt output can be raised when the data FIFO reaches half full, or on a data FIFO error. Reading status acknowledges it. The converter itself is outside the block: the block issues a start pulse with a channel word and receives a done pulse with a result word.

Top module: `adc_acq_ctrl`

## Requirements
- R1: The option register (address 0, write) stores counter-start enable in bit 0, error interrupt enable in bit 1, half-full interrupt enable in bit 2 and external-start enable in bit 5. Bits 6 and 7 are ignored: writing 0xC0 enables no start source and no interrupt.
- R2: A host write to address 3 launches a conversion when the converter is idle. conv_start_o pulses for one cycle, in the cycle after the write.
- R3: With external start enabled, a rising edge of the two-flop synchronized ext_start_i launches a conversion. With it disabled the pin launches nothing. A pin that stays high launches only once. Status bit 0 shows the synchronized pin level.
- R4: With counter start enabled, each tmr_zero_i pulse launches a conversion. With it disabled the pulse launches nothing.
- R5: While a conversion is in progress, no start source launches another one.
- R6: A write to address 1 holds a low byte, and a write to address 2 pushes {data, held byte} into the channel FIFO. Each launched conversion pops the head entry and drives it on conv_chan_o, in FIFO order.
- R7: conv_done_i pushes conv_result_i into the data FIFO. Reading address 1 returns the head's low byte. Reading address 2 returns the high byte and pops. Results come out in arrival order.
- R8: Writing option bit 3 empties the data FIFO, and writing option bit 4 empties the channel FIFO. Each is a one-shot action, so later pushes are kept.
- R9: Both FIFOs are 16 deep. The status flags are active low: bit 1 data empty, bit 2 data half full (count of 8 or more), bit 3 data full, bit 4 channel empty, bit 5 channel half full, bit 6 channel full. The reset status is 0xEC.
- R10: With the half-full interrupt enabled, irq_o rises once when the data FIFO count reaches 8. It does not rise again while the count stays at 8 or above.
- R11: With the error interrupt enabled, irq_o rises on a pop read of an empty data FIFO, or on conv_done_i while the data FIFO is full. In the second case the result is dropped.
- R12: A status read (address 0) clears irq_o. An interrupt event in the same cycle wins, and irq_o stays high.
- R13: Status bit 7 reads 0 from the cycle after a launch until conv_done_i, and reads 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 2 | Host register address |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data (combinational) |
| ext_start_i | input | 1 | External start pin, asynchronous |
| tmr_zero_i | input | 1 | Timer terminal-count pulse |
| conv_start_o | output | 1 | Conversion start pulse |
| conv_chan_o | output | 16 | Channel entry for the launched conversion |
| conv_done_i | input | 1 | Conversion done pulse |
| conv_result_i | input | 16 | Conversion result |
| irq_o | output | 1 | Interrupt request |

## Verification
The status read that acknowledges the interrupt can land in the same cycle as a fresh interrupt event. The bench provokes this by filling the data FIFO with the error interrupt enabled. It then drives a status read and an overflowing done pulse on the same clock edge, and expects irq_o still high afterwards. A following status read with no event must then drop irq_o, which shows that the set took priority over the acknowledge and did not merely fail to clear.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_LO   = 2'd1;
  localparam logic [1:0] A_HI   = 2'd2;
  localparam logic [1:0] A_SOFT = 2'd3;

  localparam int B_CTR  = 0;
  localparam int B_EIE  = 1;
  localparam int B_HIE  = 2;
  localparam int B_CLRD = 3;
  localparam int B_CLRC = 4;
  localparam int B_XEN  = 5;

  typedef struct packed {
    logic ext_en;
    logic hf_ie;
    logic err_ie;
    logic ctr_en;
  } opt_t;
endpackage

// File: rtl/adc_acq_sync.sv
module adc_acq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/adc_acq_fifo.sv
module adc_acq_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         push_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                rdata_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         empty_o,
  output logic                         half_o,
  output logic                         full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign do_push = push_i && (cnt_q != FULL);
  assign do_pop  = pop_i  && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wp_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);
  assign half_o  = (cnt_q >= HALF);
  assign full_o  = (cnt_q == FULL);
endmodule

// File: rtl/adc_acq_trig.sv
module adc_acq_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_i,
  input  logic tmr_i,
  input  logic ext_i,
  input  logic ctr_en_i,
  input  logic ext_en_i,
  input  logic done_i,
  output logic fire_o,
  output logic start_o,
  output logic busy_o
);
  logic ext_prev_q, ext_rise, busy_q, start_q;

  assign ext_rise = ext_i && !ext_prev_q;
  assign fire_o   = !busy_q && (soft_i || (ctr_en_i && tmr_i) || (ext_en_i && ext_rise));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_prev_q <= 1'b0;
      busy_q     <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      ext_prev_q <= ext_i;
      start_q    <= fire_o;
      if (fire_o)      busy_q <= 1'b1;
      else if (done_i) busy_q <= 1'b0;
    end
  end

  assign start_o = start_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/adc_acq_irq.sv
module adc_acq_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hf_ie_i,
  input  logic err_ie_i,
  input  logic half_i,
  input  logic under_i,
  input  logic over_i,
  input  logic ack_i,
  output logic irq_o
);
  logic hf_prev_q, irq_q, hf_ev, err_ev;

  assign hf_ev  = hf_ie_i && half_i && !hf_prev_q;
  assign err_ev = err_ie_i && (under_i || over_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hf_prev_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      hf_prev_q <= half_i;
      if (hf_ev || err_ev) irq_q <= 1'b1;  // new event beats ack
      else if (ack_i)      irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl
  import adc_acq_pkg::*;
#(
  parameter int DW          = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    host_addr_i,
  input  logic          host_wr_i,
  input  logic          host_rd_i,
  input  logic [7:0]    host_wdata_i,
  output logic [7:0]    host_rdata_o,
  input  logic          ext_start_i,
  input  logic          tmr_zero_i,
  output logic          conv_start_o,
  output logic [DW-1:0] conv_chan_o,
  input  logic          conv_done_i,
  input  logic [DW-1:0] conv_result_i,
  output logic          irq_o
);
  localparam int CW = $clog2(DEPTH+1);

  opt_t          opt_q;
  logic [7:0]    lo_hold_q;
  logic [DW-1:0] chan_q;
  logic          wr_ctrl, wr_lo, wr_hi, wr_soft, rd_ctrl, rd_pop;
  logic          clr_data, clr_chan, ext_s, fire, busy;
  logic [DW-1:0] ch_head, d_head;
  logic [CW-1:0] ch_cnt, d_cnt;
  logic          ch_empty, ch_half, ch_full, d_empty, d_half, d_full;
  logic          d_push, d_pop, under, over;
  logic [7:0]    status;

  assign wr_ctrl  = host_wr_i && (host_addr_i == A_CTRL);
  assign wr_lo    = host_wr_i && (host_addr_i == A_LO);
  assign wr_hi    = host_wr_i && (host_addr_i == A_HI);
  assign wr_soft  = host_wr_i && (host_addr_i == A_SOFT);
  assign rd_ctrl  = host_rd_i && (host_addr_i == A_CTRL);
  assign rd_pop   = host_rd_i && (host_addr_i == A_HI);
  assign clr_data = wr_ctrl && host_wdata_i[B_CLRD];
  assign clr_chan = wr_ctrl && host_wdata_i[B_CLRC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opt_q     <= '0;
      lo_hold_q <= '0;
    end else begin
      if (wr_ctrl) begin
        opt_q.ext_en <= host_wdata_i[B_XEN];
        opt_q.hf_ie  <= host_wdata_i[B_HIE];
        opt_q.err_ie <= host_wdata_i[B_EIE];
        opt_q.ctr_en <= host_wdata_i[B_CTR];
      end
      if (wr_lo) lo_hold_q <= host_wdata_i;
    end
  end

  adc_acq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_start_i),
    .q_o   (ext_s)
  );

  adc_acq_trig u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .soft_i  (wr_soft),
    .tmr_i   (tmr_zero_i),
    .ext_i   (ext_s),
    .ctr_en_i(opt_q.ctr_en),
    .ext_en_i(opt_q.ext_en),
    .done_i  (conv_done_i),
    .fire_o  (fire),
    .start_o (conv_start_o),
    .busy_o  (busy)
  );

  adc_acq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_chan_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_chan),
    .push_i (wr_hi),
    .wdata_i({host_wdata_i, lo_hold_q}),
    .pop_i  (fire),
    .rdata_o(ch_head),
    .count_o(ch_cnt),
    .empty_o(ch_empty),
    .half_o (ch_half),
    .full_o (ch_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   chan_q <= '0;
    else if (fire) chan_q <= ch_empty ? '0 : ch_head;
  end
  assign conv_chan_o = chan_q;

  assign d_push = conv_done_i;
  assign d_pop  = rd_pop;
  assign under  = rd_pop && d_empty;
  assign over   = conv_done_i && d_full;

  adc_acq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_data_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_data),
    .push_i (d_push),
    .wdata_i(conv_result_i),
    .pop_i  (d_pop),
    .rdata_o(d_head),
    .count_o(d_cnt),
    .empty_o(d_empty),
    .half_o (d_half),
    .full_o (d_full)
  );

  adc_acq_irq u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hf_ie_i (opt_q.hf_ie),
    .err_ie_i(opt_q.err_ie),
    .half_i  (d_half),
    .under_i (under),
    .over_i  (over),
    .ack_i   (rd_ctrl),
    .irq_o   (irq_o)
  );

  assign status = {~busy, ~ch_full, ~ch_half, ~ch_empty, ~d_full, ~d_half, ~d_empty, ext_s};

  always_comb begin
    unique case (host_addr_i)
      A_CTRL:  host_rdata_o = status;
      A_LO:    host_rdata_o = d_head[7:0];
      A_HI:    host_rdata_o = d_head[15:8];
      default: host_rdata_o = 8'h00;
    endcase
  end
endmodule

module adc_acq_ctrl_chk #(
  parameter int CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          conv_start_o,
  input logic          busy,
  input logic          conv_done_i,
  input logic          d_full,
  input logic          d_half,
  input logic          d_empty,
  input logic          d_pop,
  input logic          clr_data,
  input logic          irq_o,
  input logic          hf_ie,
  input logic          err_ie,
  input logic [CW-1:0] d_cnt
);
  a_r5_no_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> !conv_start_o);

  a_r13_busy_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> busy);

  a_r11_overflow_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && d_full && !d_pop && !clr_data) |=> (d_full && $stable(d_cnt)));

  a_r9_full_implies_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_full |-> (d_half && !d_empty));

  a_r8_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_data |=> d_empty);

  a_r12_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(hf_ie || err_ie));
endmodule

bind adc_acq_ctrl adc_acq_ctrl_chk #(.CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .conv_start_o(conv_start_o),
  .busy        (busy),
  .conv_done_i (conv_done_i),
  .d_full      (d_full),
  .d_half      (d_half),
  .d_empty     (d_empty),
  .d_pop       (d_pop),
  .clr_data    (clr_data),
  .irq_o       (irq_o),
  .hf_ie       (opt_q.hf_ie),
  .err_ie      (opt_q.err_ie),
  .d_cnt       (d_cnt)
);

// File: tb/adc_acq_ctrl_test.sv
module adc_acq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        ext = 1'b0, tmr = 1'b0, done = 1'b0;
  logic [15:0] result = '0;
  logic        start;
  logic [15:0] chan;
  logic        irq;

  int checks = 0, errors = 0, start_cnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_acq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(addr), .host_wr_i(wr), .host_rd_i(rd),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .ext_start_i(ext), .tmr_zero_i(tmr),
    .conv_start_o(start), .conv_chan_o(chan), .conv_done_i(done), .conv_result_i(result),
    .irq_o(irq)
  );

  always @(negedge clk) if (start) start_cnt++;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; #1;
  endtask

  task automatic host_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1; d = rdata;
    @(negedge clk); rd = 1'b0; #1;
  endtask

  task automatic conv_done(logic [15:0] r);
    @(negedge clk); result = r; done = 1'b1;
    @(negedge clk); done = 1'b0; #1;
  endtask

  task automatic tmr_pulse();
    @(negedge clk); tmr = 1'b1;
    @(negedge clk); tmr = 1'b0; #1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] s;
    check("R9 reset irq", 16'(irq), 16'd0);
    check("R2 reset start", 16'(start), 16'd0);
    host_read(2'd0, s);
    check("R9 reset status", 16'(s), 16'h00EC);
  endtask

  task automatic t_soft();
    logic [7:0] s, lo, hi;
    int c0;
    c0 = start_cnt;
    host_write(2'd3, 8'h00);
    check("R2 soft start", 16'(start_cnt - c0), 16'd1);
    host_read(2'd0, s);
    check("R13 busy low", 16'(s[7]), 16'd0);
    host_write(2'd3, 8'h00);
    tmr_pulse();
    idle(2);
    check("R5 no restart busy", 16'(start_cnt - c0), 16'd1);
    conv_done(16'h1234);
    host_read(2'd0, s);
    check("R13 busy idle", 16'(s[7]), 16'd1);
    check("R9 data not empty", 16'(s[1]), 16'd1);
    host_read(2'd1, lo);
    host_read(2'd2, hi);
    check("R7 result", {hi, lo}, 16'h1234);
    host_read(2'd0, s);
    check("R9 data empty", 16'(s[1]), 16'd0);
  endtask

  task automatic t_chan();
    logic [7:0] s;
    host_write(2'd1, 8'h05); host_write(2'd2, 8'h0A);
    host_write(2'd1, 8'h06); host_write(2'd2, 8'h0B);
    host_read(2'd0, s);
    check("R9 chan not empty", 16'(s[4]), 16'd1);
    host_write(2'd3, 8'h00);
    check("R6 first entry", chan, 16'h0A05);
    conv_done(16'h0001);
    host_write(2'd3, 8'h00);
    check("R6 second entry", chan, 16'h0B06);
    conv_done(16'h0002);
    host_read(2'd0, s);
    check("R6 chan drained", 16'(s[4]), 16'd0);
    host_write(2'd0, 8'h08);
    host_read(2'd0, s);
    check("R8 data clear", 16'(s[1]), 16'd0);
    conv_done(16'h0003);
    host_read(2'd0, s);
    check("R8 clear one-shot", 16'(s[1]), 16'd1);
    host_write(2'd1, 8'h11); host_write(2'd2, 8'h22);
    host_write(2'd0, 8'h18);
    host_read(2'd0, s);
    check("R8 chan clear", 16'(s[4]), 16'd0);
  endtask

  task automatic t_ext();
    logic [7:0] s;
    int c0;
    c0 = start_cnt;
    host_write(2'd0, 8'h20);
    @(negedge clk); ext = 1'b1;
    idle(4);
    check("R3 ext start", 16'(start_cnt - c0), 16'd1);
    host_read(2'd0, s);
    check("R3 ext level", 16'(s[0]), 16'd1);
    conv_done(16'h0004);
    idle(3);
    check("R3 held pin once", 16'(start_cnt - c0), 16'd1);
    @(negedge clk); ext = 1'b0;
    idle(3);
    host_write(2'd0, 8'h08);
    @(negedge clk); ext = 1'b1;
    idle(4);
    check("R3 ext disabled", 16'(start_cnt - c0), 16'd1);
    @(negedge clk); ext = 1'b0;
    idle(3);
    host_read(2'd0, s);
    check("R3 ext low", 16'(s[0]), 16'd0);
  endtask

  task automatic t_timer();
    int c0;
    c0 = start_cnt;
    host_write(2'd0, 8'h01);
    tmr_pulse();
    idle(1);
    check("R4 timer start", 16'(start_cnt - c0), 16'd1);
    conv_done(16'h0005);
    host_write(2'd0, 8'h08);
    tmr_pulse();
    idle(2);
    check("R4 timer disabled", 16'(start_cnt - c0), 16'd1);
    host_write(2'd0, 8'hC0);
    tmr_pulse();
    @(negedge clk); ext = 1'b1;
    idle(4);
    @(negedge clk); ext = 1'b0;
    idle(3);
    check("R1 reserved bits start", 16'(start_cnt - c0), 16'd1);
    check("R1 reserved bits irq", 16'(irq), 16'd0);
  endtask

  task automatic t_fill();
    logic [7:0] s, lo, hi;
    host_write(2'd0, 8'h0C);
    for (int i = 0; i < 7; i++) conv_done(16'h0100 + 16'(i));
    idle(2);
    check("R10 below half", 16'(irq), 16'd0);
    conv_done(16'h0107);
    idle(2);
    check("R10 half irq", 16'(irq), 16'd1);
    host_read(2'd0, s);
    check("R9 half flag", 16'(s[2]), 16'd0);
    check("R12 status ack", 16'(irq), 16'd0);
    for (int i = 8; i < 15; i++) conv_done(16'h0100 + 16'(i));
    idle(2);
    check("R10 single rise", 16'(irq), 16'd0);
    conv_done(16'h010F);
    host_read(2'd0, s);
    check("R9 full flag", 16'(s[3]), 16'd0);
    host_write(2'd0, 8'h02);
    conv_done(16'hBEEF);
    check("R11 overflow irq", 16'(irq), 16'd1);
    @(negedge clk); addr = 2'd0; rd = 1'b1; result = 16'hCAFE; done = 1'b1;
    @(negedge clk); rd = 1'b0; done = 1'b0; #1;
    check("R12 event beats ack", 16'(irq), 16'd1);
    host_read(2'd0, s);
    check("R12 ack clears", 16'(irq), 16'd0);
    for (int i = 0; i < 16; i++) begin
      host_read(2'd1, lo);
      host_read(2'd2, hi);
      check("R7 fifo order", {hi, lo}, 16'h0100 + 16'(i));
    end
    host_read(2'd0, s);
    check("R11 overflow dropped", 16'(s[1]), 16'd0);
    check("R11 no irq on drain", 16'(irq), 16'd0);
    host_read(2'd2, hi);
    check("R11 underflow irq", 16'(irq), 16'd1);
    host_read(2'd0, s);
    check("R12 clear after underflow", 16'(irq), 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_soft();
    t_chan();
    t_ext();
    t_timer();
    t_fill();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule